// File: doc/BRIEF.md
# Sequencer Mailbox Control Register

This block is the one control and status word that a host bus and an embedded microsequencer share. It holds three things. The first is a hold flag that keeps the sequencer in reset. The second is an eight-bit status byte that only the sequencer may write. The third is an eight-bit trigger byte. The host can only set trigger bits, and the sequencer can only clear them. The hold flag also decides which memory the host can reach. While the sequencer is held, the host can load the program area and the data RAM is closed to it. Once the sequencer is released, the two swap.

A two-state controller tracks the hold flag. Its states are `SEQ_HELD` and `SEQ_LIVE`. The transition `release` (`SEQ_HELD` to `SEQ_LIVE`) happens on a host write with bit 31 at 0. The transition `rehold` (`SEQ_LIVE` to `SEQ_HELD`) happens on a host write with bit 31 at 1. Any other cycle keeps the current state. The reset state comes from the parameter `PROG_IN_RAM`. With program RAM the block starts in `SEQ_HELD`, so firmware can be loaded first. With program ROM it starts in `SEQ_LIVE`. Starting an operation through the function-register port, with the run flag set and a nonzero operation code, sets trigger bit 0 on its own. The inverse of status bit 8 is driven out as an interrupt term that the run logic ORs in.

Top module: `seq_mailbox_ctl`

## Requirements
- R1: After reset, bit 31 of `host_rdata` equals `PROG_IN_RAM`, and all other bits are 0. With `PROG_IN_RAM`=1 the word reads 0x80000000. With `PROG_IN_RAM`=0 it reads 0x00000000.
- R2: A host write with bit 31 at 0 moves the state from `SEQ_HELD` to `SEQ_LIVE`. A host write with bit 31 at 1 moves it from `SEQ_LIVE` to `SEQ_HELD`. `seq_reset` shows the new state from the next cycle onward.
- R3: In `SEQ_HELD`, `prog_access`=1 and `data_access`=0. In `SEQ_LIVE` the two values are swapped.
- R4: Status sits in `host_rdata[15:8]`. A sequencer write in `SEQ_LIVE` loads `seq_wdata[15:8]` into it. Host writes never change it, and host writes to bits [30:16] have no effect (those bits read 0).
- R5: `seq_irq_n` equals the inverse of status bit 8 (the status byte's bit 0).
- R6: A host write sets each trigger bit `host_wdata[i]` (i < 8) that is 1. Host write bits that are 0 leave the trigger bits unchanged.
- R7: A sequencer write in `SEQ_LIVE` clears each trigger bit where `seq_wdata[i]` is 0. Bits written as 1 are unchanged, so the sequencer can never set a trigger bit.
- R8: When the host sets a trigger bit and the sequencer clears it in the same cycle, the bit ends up at 1.
- R9: When `fn_wr`, `fn_run` and a nonzero `fn_op` occur together, trigger bit 0 is set. When `fn_op` is 0, nothing changes.
- R10: While the state is `SEQ_HELD`, sequencer writes change neither the status byte nor the trigger byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register readback |
| fn_wr | input | 1 | Function-register write strobe |
| fn_run | input | 1 | Run flag in that write |
| fn_op | input | 3 | Sequencer operation code in that write |
| seq_wr | input | 1 | Sequencer write strobe |
| seq_wdata | input | 16 | Sequencer write data (status in [15:8], trigger clear mask in [7:0]) |
| seq_reset | output | 1 | Holds the sequencer in reset |
| prog_access | output | 1 | Host may reach the program area |
| data_access | output | 1 | Host may reach the data RAM |
| seq_irq_n | output | 1 | Inverse of status bit 8 |
| trig | output | 8 | Trigger byte |

## Verification
Every piece of state in this block is one flop deep, so a wrong internal value shows up at `host_rdata` in the cycle right after the write that caused it. A state register stuck in the wrong state flips `seq_reset`, `prog_access` and `data_access` all together. It also shows as sequencer writes that are either taken or dropped against expectation. A trigger cell with reversed priority or the wrong clear polarity reads back with a wrong bit on the next readback. The directed cases therefore sample one cycle after each stimulus.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic {
        SEQ_HELD = 1'b0,
        SEQ_LIVE = 1'b1
    } seq_state_e;
endpackage

// File: rtl/mbx_seq_fsm.sv
module mbx_seq_fsm
    import mbx_pkg::*;
#(
    parameter bit START_HELD = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_wr,
    input  logic host_hold_bit,
    output logic held,
    output logic prog_window,
    output logic data_window
);
    localparam seq_state_e RST_STATE = START_HELD ? SEQ_HELD : SEQ_LIVE;

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_HELD: if (host_wr && !host_hold_bit) state_d = SEQ_LIVE; // release
            SEQ_LIVE: if (host_wr &&  host_hold_bit) state_d = SEQ_HELD; // rehold
            default:  state_d = RST_STATE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_STATE;
        else        state_q <= state_d;
    end

    always_comb begin
        held        = 1'b0;
        prog_window = 1'b0;
        data_window = 1'b0;
        unique case (state_q)
            SEQ_HELD: begin
                held        = 1'b1;
                prog_window = 1'b1;
            end
            SEQ_LIVE: data_window = 1'b1;
            default:  held = 1'b1;
        endcase
    end

    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_HELD && host_wr && !host_hold_bit) |=> (state_q == SEQ_LIVE));
    a_r2_rehold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_LIVE && host_wr && host_hold_bit) |=> (state_q == SEQ_HELD));
    a_r2_no_host_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr) |=> $stable(held));
endmodule

// File: rtl/mbx_status_reg.sv
module mbx_status_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_wr,
    input  logic             live,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    logic take;
    assign take = seq_wr && live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (take) q <= wdata;
    end

    a_r10_held_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!live) |=> $stable(q));
    a_r4_seq_load: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_wr && live) |=> (q == $past(wdata)));
endmodule

// File: rtl/mbx_trig_bank.sv
module mbx_trig_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [WIDTH-1:0] host_bits,
    input  logic             auto_set0,
    input  logic             seq_wr,
    input  logic             live,
    input  logic [WIDTH-1:0] seq_bits,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] set_v;
    logic [WIDTH-1:0] clr_v;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        if (i == 0) begin : g_auto
            assign set_v[i] = (host_wr && host_bits[i]) || auto_set0;
        end else begin : g_plain
            assign set_v[i] = host_wr && host_bits[i];
        end
        assign clr_v[i] = seq_wr && live && !seq_bits[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q[i] <= 1'b0;
            else if (set_v[i])  q[i] <= 1'b1;
            else if (clr_v[i])  q[i] <= 1'b0;
        end

        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && host_bits[i]) |=> q[i]);
        a_r7_seq_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (!(host_wr && host_bits[i]) && !(i == 0 && auto_set0) && !q[i]) |=> !q[i]);
        a_r10_held_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (!live && q[i]) |=> q[i]);
    end

    a_r9_auto_set: assert property (@(posedge clk) disable iff (!rst_n)
        auto_set0 |=> q[0]);
endmodule

// File: rtl/seq_mailbox_ctl.sv
module seq_mailbox_ctl #(
    parameter bit PROG_IN_RAM = 1'b1,
    parameter int DATA_W      = 32,
    parameter int TRIG_W      = 8,
    parameter int STAT_W      = 8,
    parameter int OP_W        = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic [DATA_W-1:0]        host_rdata,
    input  logic                     fn_wr,
    input  logic                     fn_run,
    input  logic [OP_W-1:0]          fn_op,
    input  logic                     seq_wr,
    input  logic [TRIG_W+STAT_W-1:0] seq_wdata,
    output logic                     seq_reset,
    output logic                     prog_access,
    output logic                     data_access,
    output logic                     seq_irq_n,
    output logic [TRIG_W-1:0]        trig
);
    localparam int STAT_LSB = TRIG_W;
    localparam int HOLD_POS = DATA_W - 1;
    localparam int PAD_LSB  = STAT_LSB + STAT_W;

    logic              held;
    logic              auto_set0;
    logic [STAT_W-1:0] status;

    assign auto_set0 = fn_wr && fn_run && (fn_op != '0);

    mbx_seq_fsm #(.START_HELD(PROG_IN_RAM)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr      (host_wr),
        .host_hold_bit(host_wdata[HOLD_POS]),
        .held         (held),
        .prog_window  (prog_access),
        .data_window  (data_access)
    );

    mbx_status_reg #(.WIDTH(STAT_W)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .seq_wr(seq_wr),
        .live  (!held),
        .wdata (seq_wdata[STAT_LSB +: STAT_W]),
        .q     (status)
    );

    mbx_trig_bank #(.WIDTH(TRIG_W)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_wr  (host_wr),
        .host_bits(host_wdata[TRIG_W-1:0]),
        .auto_set0(auto_set0),
        .seq_wr   (seq_wr),
        .live     (!held),
        .seq_bits (seq_wdata[TRIG_W-1:0]),
        .q        (trig)
    );

    assign seq_reset = held;
    assign seq_irq_n = !status[0];

    always_comb begin
        host_rdata                       = '0;
        host_rdata[HOLD_POS]             = held;
        host_rdata[STAT_LSB +: STAT_W]   = status;
        host_rdata[TRIG_W-1:0]           = trig;
    end

    logic unused_host_bits;
    assign unused_host_bits = ^{host_wdata[HOLD_POS-1:PAD_LSB], host_wdata[STAT_LSB +: STAT_W]};

    a_r3_windows_follow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_wdata[HOLD_POS]) |=> (prog_access && !data_access));
    a_r4_host_no_status: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_wr) |=> $stable(host_rdata[STAT_LSB +: STAT_W]));
endmodule

// File: tb/seq_mailbox_ctl_bench.sv
module seq_mailbox_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        fn_wr = 1'b0;
    logic        fn_run = 1'b0;
    logic [2:0]  fn_op = '0;
    logic        seq_wr = 1'b0;
    logic [15:0] seq_wdata = '0;
    logic [31:0] host_rdata, rom_rdata;
    logic        seq_reset, prog_access, data_access, seq_irq_n;
    logic        rom_reset, rom_prog, rom_data, rom_irq;
    logic [7:0]  trig, rom_trig;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    seq_mailbox_ctl u_seq_mailbox_ctl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .fn_wr(fn_wr), .fn_run(fn_run), .fn_op(fn_op),
        .seq_wr(seq_wr), .seq_wdata(seq_wdata), .seq_reset(seq_reset),
        .prog_access(prog_access), .data_access(data_access),
        .seq_irq_n(seq_irq_n), .trig(trig)
    );

    seq_mailbox_ctl #(.PROG_IN_RAM(1'b0)) u_seq_mailbox_ctl_rom (
        .clk(clk), .rst_n(rst_n), .host_wr(1'b0), .host_wdata(32'h0),
        .host_rdata(rom_rdata), .fn_wr(1'b0), .fn_run(1'b0), .fn_op(3'd0),
        .seq_wr(1'b0), .seq_wdata(16'h0), .seq_reset(rom_reset),
        .prog_access(rom_prog), .data_access(rom_data),
        .seq_irq_n(rom_irq), .trig(rom_trig)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] d);
        host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic seq_write(input logic [15:0] d);
        seq_wr = 1'b1; seq_wdata = d;
        @(negedge clk);
        seq_wr = 1'b0; seq_wdata = '0;
    endtask

    task automatic start_op(input logic run, input logic [2:0] op);
        fn_wr = 1'b1; fn_run = run; fn_op = op;
        @(negedge clk);
        fn_wr = 1'b0; fn_run = 1'b0; fn_op = '0;
    endtask

    task automatic t_reset;
        chk("R1 ram reset word", host_rdata, 32'h8000_0000);
        chk("R1 ram seq_reset", {31'd0, seq_reset}, 32'd1);
        chk("R1 rom reset word", rom_rdata, 32'h0);
        chk("R1 rom seq_reset", {31'd0, rom_reset}, 32'd0);
        chk("R3 rom windows", {30'd0, rom_prog, rom_data}, 32'd1);
        chk("R3 held windows", {30'd0, prog_access, data_access}, 32'd2);
        chk("R5 irq at reset", {31'd0, seq_irq_n}, 32'd1);
        chk("R1 rom trig", {24'd0, rom_trig}, 32'd0);
        chk("R5 rom irq", {31'd0, rom_irq}, 32'd1);
    endtask

    task automatic t_held_ignores_seq;
        host_write(32'h8000_0003);
        chk("R6 set in held", host_rdata, 32'h8000_0003);
        seq_write(16'hAA00);
        chk("R10 seq write ignored in held", host_rdata, 32'h8000_0003);
    endtask

    task automatic t_release;
        host_write(32'h0000_0000);
        chk("R2 release", {31'd0, seq_reset}, 32'd0);
        chk("R3 live windows", {30'd0, prog_access, data_access}, 32'd1);
        chk("R6 zero write keeps trig", host_rdata, 32'h0000_0003);
    endtask

    task automatic t_status;
        seq_write(16'h5503);
        chk("R4 status load", host_rdata, 32'h0000_5503);
        chk("R5 irq low when bit8 set", {31'd0, seq_irq_n}, 32'd0);
        host_write(32'h0000_FF00);
        chk("R4 host cannot write status", host_rdata, 32'h0000_5503);
        host_write(32'h7FFF_0000);
        chk("R4 pad bits ignored", host_rdata, 32'h0000_5503);
        seq_write(16'h5400);
        chk("R7 seq clears all", host_rdata, 32'h0000_5400);
        chk("R5 irq high when bit8 clear", {31'd0, seq_irq_n}, 32'd1);
    endtask

    task automatic t_set_clear;
        host_write(32'h0000_00A0);
        chk("R6 host sets", {24'd0, trig}, 32'hA0);
        host_write(32'h0000_0000);
        chk("R6 zeros no effect", {24'd0, trig}, 32'hA0);
        seq_write(16'h54DF);
        chk("R7 seq clears one", {24'd0, trig}, 32'h80);
        seq_write(16'h54FF);
        chk("R7 seq cannot set", {24'd0, trig}, 32'h80);
    endtask

    task automatic t_race;
        host_wr = 1'b1; host_wdata = 32'h0000_0001;
        seq_wr = 1'b1; seq_wdata = 16'h5400;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0; seq_wr = 1'b0; seq_wdata = '0;
        chk("R8 host set wins", {24'd0, trig}, 32'h01);
    endtask

    task automatic t_start;
        seq_write(16'h5400);
        chk("R7 cleared before start", {24'd0, trig}, 32'h0);
        start_op(1'b1, 3'd0);
        chk("R9 zero op no set", {24'd0, trig}, 32'h0);
        start_op(1'b0, 3'd3);
        chk("R9 no run no set", {24'd0, trig}, 32'h0);
        start_op(1'b1, 3'd5);
        chk("R9 run with op sets bit0", {24'd0, trig}, 32'h01);
    endtask

    task automatic t_rehold;
        host_write(32'h8000_0000);
        chk("R2 rehold", {31'd0, seq_reset}, 32'd1);
        chk("R3 held again", {30'd0, prog_access, data_access}, 32'd2);
        seq_write(16'h0000);
        chk("R10 held blocks clear and status", host_rdata, 32'h8000_5401);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_held_ignores_seq();
        t_release();
        t_status();
        t_set_clear();
        t_race();
        t_start();
        t_rehold();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule